// File: doc/BRIEF.md
# Contactless Transmit Byte Framer

This block serialises a stream of bytes for a short-range card link. After a start-send strobe it emits a start bit, then each byte least significant bit first, each followed by a parity bit. The framing depends on the bit rate captured at the strobe. The lowest rate (rate code 0) uses a start bit of 1 and odd parity on every byte. The three faster rates (codes 1 to 3) open with a burst of subcarrier symbols, then send a start bit of 0. They use odd parity on every byte except the final one, which closes the frame with even parity.

Bytes arrive over a valid/ready handshake, with `inLast` marking the final byte. A 3-bit count, captured at the strobe, selects how many low bits of that final byte are sent. A count of zero sends the whole byte. A partial final byte carries no parity. Every symbol leaves as a one-cycle `bitStrobe` with its value on `bitOut`. Symbols are paced at least `BIT_CYCLES` clocks apart. `txDone` pulses once when the frame has fully drained.

Top module: `tx_framer`

## Requirements
- R1: With rate code 0 the frame opens directly with a start symbol of value 1, and no burst symbol is emitted.
- R2: With rate codes 1, 2 or 3 the frame opens with exactly BURST_LEN (32) symbols flagged by `burstOut` with `bitOut` = 1, followed by a start symbol of value 0.
- R3: Each byte is sent least significant bit first, as eight data symbols when it is sent whole.
- R4: With rate code 0 every whole byte is followed by an odd parity symbol, so that the byte and the parity symbol together hold an odd number of ones.
- R5: With rate codes 1 to 3 every whole byte except the final one is followed by an odd parity symbol, and a whole final byte is followed by an even parity symbol.
- R6: When the last-bits count N is 1 to 7, the final byte sends only its N low bits and no parity symbol follows. A count of 0 sends all 8 bits and the parity symbol.
- R7: The last-bits count has no effect on bytes not marked `inLast`.
- R8: `inReady` is high only while the framer waits for the next byte of an open frame, stays high until a byte is accepted, and is never high in the same cycle as `bitStrobe`.
- R9: `txDone` is high for exactly one cycle per frame, after the last symbol strobe, and no symbol follows it until the next start-send.
- R10: Two consecutive symbol strobes are at least BIT_CYCLES (4) clock cycles apart.
- R11: A start-send strobe, a change of rate code or a change of last-bits count while a frame is open has no effect on that frame.
- R12: After reset `bitStrobe`, `burstOut`, `txDone`, `bitOut` and `inReady` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startSend | input | 1 | One-cycle strobe that opens a frame when idle |
| rateSel | input | 2 | Bit rate code: 0 lowest rate, 1 to 3 faster rates |
| lastBits | input | 3 | Valid bits in the final byte, 0 means all 8 |
| inByte | input | 8 | Byte offered on the handshake |
| inValid | input | 1 | `inByte` and `inLast` are valid |
| inLast | input | 1 | The offered byte is the final byte of the frame |
| inReady | output | 1 | Framer accepts a byte in this cycle |
| bitOut | output | 1 | Symbol value, valid while `bitStrobe` is high |
| bitStrobe | output | 1 | One-cycle strobe per emitted symbol |
| burstOut | output | 1 | The strobed symbol belongs to the opening burst |
| txDone | output | 1 | One-cycle pulse when the frame has completed |

## Verification
A byte handshake and a new start-send request can land in the same clock cycle. The bench raises `startSend` in the exact cycle in which the second byte of a faster-rate frame is taken. It also changes the rate code and the last-bits count right after the frame opens. The captured symbol sequence must still match the one computed from the first settings alone, with one `txDone` and no stray symbols afterwards. The collision of the final parity choice with the last-byte flag is judged by comparing odd parity on the middle bytes against even parity on the closing byte of the same frame.

// File: rtl/tx_frame_pkg.sv
package tx_frame_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PREAMBLE,
    ST_START,
    ST_FETCH,
    ST_DATA,
    ST_PARITY,
    ST_FINISH,
    ST_DONE
  } txState_t;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic loadByte;
    logic emitPre;
    logic emitStart;
    logic emitData;
    logic emitParity;
    logic startVal;
    logic parityEven;
  } txCtrl_t;

endpackage

// File: rtl/tx_frame_timer.sv
module tx_frame_timer #(
  parameter int BIT_CYCLES = 4
) (
  input  logic clk,
  input  logic rstN,
  input  logic kick,
  output logic slotFree
);
  localparam int CW = (BIT_CYCLES > 2) ? $clog2(BIT_CYCLES) : 1;

  logic [CW-1:0] slotCnt;

  // a symbol occupies BIT_CYCLES clocks counted from its emit command
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotCnt <= '0;
    end else if (kick) begin
      slotCnt <= CW'(BIT_CYCLES - 1);
    end else if (slotCnt != '0) begin
      slotCnt <= slotCnt - CW'(1);
    end
  end

  assign slotFree = (slotCnt == '0);

endmodule

// File: rtl/tx_frame_datapath.sv
module tx_frame_datapath
  import tx_frame_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  txCtrl_t           ctrl,
  input  logic [BYTE_W-1:0] inByte,
  output logic              bitOut,
  output logic              bitStrobe,
  output logic              burstOut
);
  logic [BYTE_W-1:0] shiftReg;
  logic              byteParity;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg   <= '0;
      byteParity <= 1'b0;
      bitOut     <= 1'b0;
      bitStrobe  <= 1'b0;
      burstOut   <= 1'b0;
    end else begin
      bitStrobe <= ctrl.emitPre | ctrl.emitStart | ctrl.emitData | ctrl.emitParity;
      burstOut  <= ctrl.emitPre;
      if (ctrl.loadByte) begin
        shiftReg   <= inByte;
        byteParity <= ^inByte;
      end else if (ctrl.emitData) begin
        shiftReg <= {1'b0, shiftReg[BYTE_W-1:1]};
      end
      if (ctrl.emitData) begin
        bitOut <= shiftReg[0];
      end else if (ctrl.emitParity) begin
        // even parity repeats the byte's XOR, odd parity inverts it
        bitOut <= ctrl.parityEven ? byteParity : ~byteParity;
      end else if (ctrl.emitStart) begin
        bitOut <= ctrl.startVal;
      end else if (ctrl.emitPre) begin
        bitOut <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/tx_frame_ctrl.sv
module tx_frame_ctrl
  import tx_frame_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int BURST_LEN = 32
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      startSend,
  input  logic [1:0]                rateSel,
  input  logic [$clog2(BYTE_W)-1:0] lastBits,
  input  logic                      inValid,
  input  logic                      inLast,
  input  logic                      slotFree,
  output txCtrl_t                   ctrl,
  output logic                      inReady,
  output logic                      txDone
);
  localparam int LB_W  = $clog2(BYTE_W);
  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam int PRE_W = $clog2(BURST_LEN + 1);

  txState_t         state;
  logic             hiRate;
  logic [LB_W-1:0]  lastBitsQ;
  logic             lastByteQ;
  logic             partialQ;
  logic [CNT_W-1:0] bitIdx;
  logic [CNT_W-1:0] bitsToSend;
  logic [PRE_W-1:0] preCnt;
  logic             takeByte;

  always_comb begin
    ctrl            = '0;
    ctrl.startVal   = ~hiRate;
    ctrl.parityEven = hiRate & lastByteQ;
    inReady         = 1'b0;
    unique case (state)
      ST_PREAMBLE: ctrl.emitPre    = slotFree;
      ST_START:    ctrl.emitStart  = slotFree;
      ST_FETCH:    inReady         = slotFree;
      ST_DATA:     ctrl.emitData   = slotFree;
      ST_PARITY:   ctrl.emitParity = slotFree;
      default:     ;
    endcase
    takeByte      = inReady & inValid;
    ctrl.loadByte = takeByte;
  end

  assign txDone = (state == ST_DONE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      hiRate     <= 1'b0;
      lastBitsQ  <= '0;
      lastByteQ  <= 1'b0;
      partialQ   <= 1'b0;
      bitIdx     <= '0;
      bitsToSend <= '0;
      preCnt     <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (startSend) begin
            hiRate    <= (rateSel != 2'd0);
            lastBitsQ <= lastBits;
            lastByteQ <= 1'b0;
            preCnt    <= '0;
            state     <= (rateSel != 2'd0) ? ST_PREAMBLE : ST_START;
          end
        end
        ST_PREAMBLE: begin
          if (slotFree) begin
            preCnt <= preCnt + PRE_W'(1);
            if (preCnt == PRE_W'(BURST_LEN - 1)) state <= ST_START;
          end
        end
        ST_START: begin
          if (slotFree) state <= ST_FETCH;
        end
        ST_FETCH: begin
          if (takeByte) begin
            lastByteQ <= inLast;
            bitIdx    <= '0;
            if (inLast && lastBitsQ != '0) begin
              partialQ   <= 1'b1;
              bitsToSend <= CNT_W'(lastBitsQ);
            end else begin
              partialQ   <= 1'b0;
              bitsToSend <= CNT_W'(BYTE_W);
            end
            state <= ST_DATA;
          end
        end
        ST_DATA: begin
          if (slotFree) begin
            bitIdx <= bitIdx + CNT_W'(1);
            if (bitIdx == bitsToSend - CNT_W'(1)) begin
              state <= partialQ ? ST_FINISH : ST_PARITY;
            end
          end
        end
        ST_PARITY: begin
          if (slotFree) state <= lastByteQ ? ST_FINISH : ST_FETCH;
        end
        ST_FINISH: begin
          if (slotFree) state <= ST_DONE;
        end
        ST_DONE: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/tx_framer.sv
module tx_framer
  import tx_frame_pkg::*;
#(
  parameter int BYTE_W     = 8,
  parameter int BIT_CYCLES = 4,
  parameter int BURST_LEN  = 32
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      startSend,
  input  logic [1:0]                rateSel,
  input  logic [$clog2(BYTE_W)-1:0] lastBits,
  input  logic [BYTE_W-1:0]         inByte,
  input  logic                      inValid,
  input  logic                      inLast,
  output logic                      inReady,
  output logic                      bitOut,
  output logic                      bitStrobe,
  output logic                      burstOut,
  output logic                      txDone
);
  txCtrl_t ctrl;
  logic    slotFree;
  logic    kick;

  assign kick = ctrl.emitPre | ctrl.emitStart | ctrl.emitData | ctrl.emitParity;

  tx_frame_ctrl #(.BYTE_W(BYTE_W), .BURST_LEN(BURST_LEN)) i_ctrl (
    .clk(clk), .rstN(rstN), .startSend(startSend), .rateSel(rateSel),
    .lastBits(lastBits), .inValid(inValid), .inLast(inLast),
    .slotFree(slotFree), .ctrl(ctrl), .inReady(inReady), .txDone(txDone)
  );

  tx_frame_timer #(.BIT_CYCLES(BIT_CYCLES)) i_timer (
    .clk(clk), .rstN(rstN), .kick(kick), .slotFree(slotFree)
  );

  tx_frame_datapath #(.BYTE_W(BYTE_W)) i_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .inByte(inByte),
    .bitOut(bitOut), .bitStrobe(bitStrobe), .burstOut(burstOut)
  );

endmodule

// File: rtl/tx_framer_chk.sv
module tx_framer_chk #(
  parameter int BIT_CYCLES = 4
) (
  input logic clk,
  input logic rstN,
  input logic inValid,
  input logic inReady,
  input logic bitOut,
  input logic bitStrobe,
  input logic burstOut,
  input logic txDone
);
  localparam int GW = $clog2(BIT_CYCLES + 1);

  logic [GW-1:0] gapCnt;
  logic          seenStrobe;

  // clocks since the last strobe, saturating at BIT_CYCLES
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gapCnt     <= '0;
      seenStrobe <= 1'b0;
    end else if (bitStrobe) begin
      gapCnt     <= '0;
      seenStrobe <= 1'b1;
    end else if (gapCnt != GW'(BIT_CYCLES)) begin
      gapCnt <= gapCnt + GW'(1);
    end
  end

  p_burst_marked_r2: assert property (@(posedge clk) disable iff (!rstN)
    burstOut |-> (bitStrobe && bitOut));

  p_ready_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    bitStrobe |-> !inReady);

  p_ready_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (inReady && !inValid) |=> inReady);

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    txDone |=> !txDone);

  p_done_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    txDone |-> (!bitStrobe && !inReady));

  p_done_no_follow_r9: assert property (@(posedge clk) disable iff (!rstN)
    txDone |=> !bitStrobe);

  p_symbol_spacing_r10: assert property (@(posedge clk) disable iff (!rstN)
    (bitStrobe && seenStrobe) |-> (gapCnt >= GW'(BIT_CYCLES - 1)));

endmodule

bind tx_framer tx_framer_chk #(.BIT_CYCLES(BIT_CYCLES)) i_chk (
  .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
  .bitOut(bitOut), .bitStrobe(bitStrobe), .burstOut(burstOut), .txDone(txDone)
);

// File: tb/test_tx_framer.sv
`timescale 1ns/1ps
module test_tx_framer;
  localparam int BITC  = 4;
  localparam int BURST = 32;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startSend = 1'b0;
  logic [1:0] rateSel = 2'd0;
  logic [2:0] lastBits = 3'd0;
  logic [7:0] inByte = 8'd0;
  logic       inValid = 1'b0;
  logic       inLast = 1'b0;
  logic       inReady, bitOut, bitStrobe, burstOut, txDone;

  tx_framer #(.BYTE_W(8), .BIT_CYCLES(BITC), .BURST_LEN(BURST)) i_tx_framer (
    .clk(clk), .rstN(rstN), .startSend(startSend), .rateSel(rateSel),
    .lastBits(lastBits), .inByte(inByte), .inValid(inValid), .inLast(inLast),
    .inReady(inReady), .bitOut(bitOut), .bitStrobe(bitStrobe),
    .burstOut(burstOut), .txDone(txDone)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;

  // captured symbols
  logic capBit [0:511];
  logic capBurst [0:511];
  int   capN = 0;
  int   doneCnt = 0;
  int   doneCyc = 0;
  int   lastStrobeCyc = 0;
  int   minGap = 1000;
  int   readyViol = 0;
  int   cyc = 0;

  // expected symbols
  logic expBit [0:511];
  logic expBurst [0:511];
  int   expN;
  logic [7:0] txBytes [0:7];

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // monitor samples 3 ns after the rising edge
  always @(posedge clk) begin
    #3;
    cyc++;
    if (bitStrobe) begin
      if (capN > 0 && (cyc - lastStrobeCyc) < minGap) minGap = cyc - lastStrobeCyc;
      if (capN < 512) begin
        capBit[capN]   = bitOut;
        capBurst[capN] = burstOut;
      end
      capN++;
      lastStrobeCyc = cyc;
      if (inReady) readyViol++;
    end
    if (txDone) begin
      doneCnt++;
      doneCyc = cyc;
    end
  end

  task automatic push_exp(input logic b, input logic burst);
    expBit[expN]   = b;
    expBurst[expN] = burst;
    expN++;
  endtask

  task automatic build_exp(input int rate, input int lb, input int n);
    expN = 0;
    if (rate != 0) for (int k = 0; k < BURST; k++) push_exp(1'b1, 1'b1);
    push_exp((rate == 0) ? 1'b1 : 1'b0, 1'b0);
    for (int i = 0; i < n; i++) begin
      int nb;
      nb = (i == n - 1 && lb != 0) ? lb : 8;
      for (int k = 0; k < nb; k++) push_exp(txBytes[i][k], 1'b0);
      if (nb == 8) begin
        if (rate != 0 && i == n - 1) push_exp(^txBytes[i], 1'b0);
        else push_exp(~(^txBytes[i]), 1'b0);
      end
    end
  endtask

  // poke: retrigger and change settings mid-frame
  task automatic run_frame(input string tag, input int rate, input int lb,
                           input int n, input int gap, input bit poke);
    int t;
    int mism;
    int firstBad;
    int capAfter;
    build_exp(rate, lb, n);
    @(negedge clk);
    capN = 0; doneCnt = 0; minGap = 1000; readyViol = 0;
    rateSel = 2'(rate); lastBits = 3'(lb); startSend = 1'b1;
    @(negedge clk);
    startSend = 1'b0;
    if (poke) begin
      rateSel  = (rate == 0) ? 2'd2 : 2'd0;
      lastBits = 3'(lb) ^ 3'd3;
    end
    for (int i = 0; i < n; i++) begin
      repeat (gap) @(negedge clk);
      inByte = txBytes[i]; inLast = (i == n - 1); inValid = 1'b1;
      t = 0;
      while (!inReady && t < 2000) begin @(negedge clk); t++; end
      if (poke && i == 1) startSend = 1'b1;
      @(negedge clk);
      inValid = 1'b0; inLast = 1'b0; startSend = 1'b0;
    end
    t = 0;
    while (doneCnt == 0 && t < 5000) begin @(negedge clk); t++; end
    capAfter = capN;
    repeat (6 * BITC) @(negedge clk);
    mism = 0; firstBad = -1;
    for (int k = 0; k < expN && k < capN && k < 512; k++) begin
      if (capBit[k] !== expBit[k] || capBurst[k] !== expBurst[k]) begin
        mism++;
        if (firstBad < 0) firstBad = k;
      end
    end
    chk(capN == expN, tag, "symbol count", capN, expN);
    chk(mism == 0, tag, "mismatching symbols (first index in next line if any)", mism, 0);
    if (mism != 0) $display("  first mismatch at symbol %0d bit %0d exp %0d", firstBad,
                            capBit[firstBad], expBit[firstBad]);
    chk(doneCnt == 1, {tag, " R9"}, "done pulses", doneCnt, 1);
    chk(doneCyc > lastStrobeCyc && capAfter == capN, {tag, " R9"},
        "strobes after done", capN - capAfter, 0);
    chk(minGap >= BITC, {tag, " R10"}, "min strobe spacing", minGap, BITC);
    chk(readyViol == 0, {tag, " R8"}, "ready during strobe", readyViol, 0);
    rateSel = 2'd0; lastBits = 3'd0;
  endtask

  task automatic test_reset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    chk(!bitStrobe && !burstOut && !txDone && !bitOut && !inReady, "R12",
        "outputs in reset", {bitStrobe, burstOut, txDone, bitOut, inReady}, 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    chk(!inReady && !bitStrobe, "R8 R12", "idle ready/strobe after reset",
        {inReady, bitStrobe}, 0);
  endtask

  task automatic test_low_rate();
    txBytes[0] = 8'hA5; txBytes[1] = 8'h3C;
    run_frame("R1 R3 R4", 0, 0, 2, 0, 1'b0);
  endtask

  task automatic test_high_rate();
    txBytes[0] = 8'h01; txBytes[1] = 8'hFE; txBytes[2] = 8'h80;
    run_frame("R2 R3 R5", 1, 0, 3, 0, 1'b0);
  endtask

  task automatic test_single_even();
    txBytes[0] = 8'h07;
    run_frame("R2 R5", 3, 0, 1, 0, 1'b0);
  endtask

  task automatic test_partial_high();
    txBytes[0] = 8'h5A; txBytes[1] = 8'hB6;
    run_frame("R6", 2, 5, 2, 0, 1'b0);
  endtask

  task automatic test_partial_low();
    txBytes[0] = 8'hC3; txBytes[1] = 8'h11; txBytes[2] = 8'hFF;
    run_frame("R6 R7", 0, 1, 3, 0, 1'b0);
  endtask

  task automatic test_stall();
    txBytes[0] = 8'h00; txBytes[1] = 8'h7F;
    run_frame("R8 R10", 0, 0, 2, 7, 1'b0);
  endtask

  task automatic test_midframe();
    txBytes[0] = 8'h96; txBytes[1] = 8'h4B; txBytes[2] = 8'hE9;
    run_frame("R11", 1, 4, 3, 0, 1'b1);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    test_reset();
    test_low_rate();
    test_high_rate();
    test_single_even();
    test_partial_high();
    test_partial_low();
    test_stall();
    test_midframe();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule